// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives an active-low system reset from two causes: a supply-good flag that an external comparator has already synchronized to the clock, and a watchdog timer. The watchdog is kicked by the falling edge of a chip-select line that is shared with a serial bus. Each bus transaction therefore restarts the timer, and no dedicated kick pin is needed.

The reset output is low during power-up reset and whenever the supply flag is low. It is also low when the enabled watchdog sees no kick within the chosen timeout. Once every cause has cleared, the output stays low for a fixed hold interval of `HOLD_CYC` cycles, and only then goes high. A two-bit code picks one of three timeout lengths, or switches the watchdog off. While reset is low, the watchdog counter stays cleared, so the timeout window starts fresh each time reset is released.

Top module: `wdog_rst_supervisor`

## Requirements
- R1: `rst_n_out` is active low and reads 0 in every cycle that `rst` is high.
- R2: `rst_n_out` reads 0 one cycle after `supply_ok` is sampled low, and stays 0 while `supply_ok` stays low.
- R3: After `rst` is released with `supply_ok` high, `rst_n_out` stays 0 for `HOLD_CYC - 1` clock edges and reads 1 after edge `HOLD_CYC`.
- R4: After `supply_ok` returns high, `rst_n_out` reads 1 exactly `HOLD_CYC` edges later and not before.
- R5: Only a high-to-low transition of `cs_kick_n` restarts the watchdog. Holding the line steadily high or steadily low lets the timeout expire.
- R6: With the watchdog enabled and no kick, `rst_n_out` reads 0 exactly L edges after it was released. L is `TMO_A` for `tmo_sel` 0, `TMO_B` for 1 and `TMO_C` for 2.
- R7: Falling edges on `cs_kick_n` spaced at less than the selected timeout keep `rst_n_out` at 1. Each edge reaches the watchdog through a two-flop synchronizer.
- R8: `tmo_sel` = 3 or `wd_en` = 0 disables the watchdog, so no watchdog-caused reset occurs.
- R9: A watchdog reset lasts `HOLD_CYC` edges. The watchdog then restarts from zero, so the next timeout comes a full L edges after that release.
- R10: When a supply drop and a timeout land on the same cycle, the supply cause wins, and the hold interval is counted from the supply's return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| supply_ok | input | 1 | Synchronized supply-good flag, 1 = supply above sense level |
| cs_kick_n | input | 1 | Chip-select line, falling edge kicks the watchdog |
| tmo_sel | input | 2 | Timeout code: 0 short, 1 medium, 2 long, 3 off |
| wd_en | input | 1 | Watchdog enable, 1 = enabled |
| rst_n_out | output | 1 | Active-low reset output |

## Verification
A table drives every timeout code with a kick line held steadily high, held steadily low, and toggled at a period below the timeout. This separates edge detection from level detection and confirms the length each code selects. The off code and a low enable run without kicks, to show that neither can cause a watchdog reset. Directed runs then cover:
- back-to-back timeouts, which show the counter restarting after the hold;
- a supply drop with the watchdog off, which separates the supply path from the timer;
- a supply drop placed on the exact cycle a timeout would fire, where the release cycle shows whether the hold was restarted from the supply's return.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    typedef enum logic [1:0] {
        TMO_SHORT = 2'd0,
        TMO_MID   = 2'd1,
        TMO_LONG  = 2'd2,
        TMO_OFF   = 2'd3
    } tmo_code_e;

    typedef struct packed {
        logic      on;
        tmo_code_e code;
    } wd_cfg_t;

    function automatic wd_cfg_t make_cfg(input logic en, input logic [1:0] sel);
        wd_cfg_t c;
        c.code = tmo_code_e'(sel);
        c.on   = en && (c.code != TMO_OFF);
        return c;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned pick_limit(input tmo_code_e code, input int unsigned a,
                                               input int unsigned b, input int unsigned c);
        case (code)
            TMO_SHORT: return a;
            TMO_MID:   return b;
            default:   return c;
        endcase
    endfunction

endpackage

// File: rtl/wrs_kick_sync.sv
module wrs_kick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign fall = last_q && !sync_q[STAGES-1];
endmodule

// File: rtl/wrs_wdog.sv
module wrs_wdog
    import wrs_pkg::*;
#(
    parameter int unsigned TMO_A = 10,
    parameter int unsigned TMO_B = 20,
    parameter int unsigned TMO_C = 40
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    kick,
    input  wd_cfg_t cfg,
    output logic    expire
);
    localparam int unsigned TMAX = max3(TMO_A, TMO_B, TMO_C);
    localparam int unsigned CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;

    always_comb begin
        lim_m1 = CW'(pick_limit(cfg.code, TMO_A, TMO_B, TMO_C) - 1);
    end

    assign expire = cfg.on && (cnt_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || clr || !cfg.on || kick || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wrs_hold_ctl.sv
module wrs_hold_ctl #(
    parameter int unsigned HOLD_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic wd_expire,
    output logic active
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            active <= 1'b1;
            hold_q <= '0;
        end else if (active) begin
            if (hold_q == HW'(HOLD_CYC - 1)) begin
                active <= 1'b0;
                hold_q <= '0;
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end else if (wd_expire) begin
            active <= 1'b1;
            hold_q <= '0;
        end
    end
endmodule

// File: rtl/wdog_rst_supervisor.sv
module wdog_rst_supervisor
    import wrs_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 10_000_000,
    parameter int unsigned TMO_A    = 7_500_000,
    parameter int unsigned TMO_B    = 30_000_000,
    parameter int unsigned TMO_C    = 70_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       cs_kick_n,
    input  logic [1:0] tmo_sel,
    input  logic       wd_en,
    output logic       rst_n_out
);
    logic    kick;
    logic    wd_expire;
    logic    hold_active;
    wd_cfg_t cfg;

    assign cfg = make_cfg(wd_en, tmo_sel);

    wrs_kick_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cs_kick_n),
        .fall (kick)
    );

    wrs_wdog #(.TMO_A(TMO_A), .TMO_B(TMO_B), .TMO_C(TMO_C)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold_active),
        .kick   (kick),
        .cfg    (cfg),
        .expire (wd_expire)
    );

    wrs_hold_ctl #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .wd_expire (wd_expire),
        .active    (hold_active)
    );

    assign rst_n_out = !hold_active;
endmodule

// File: rtl/wrs_checker.sv
module wrs_checker #(
    parameter int unsigned HOLD_CYC = 20
) (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic [1:0] tmo_sel,
    input logic       wd_en,
    input logic       rst_n_out,
    input logic       wd_expire
);
    localparam int unsigned LW = $clog2(HOLD_CYC + 2);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok || rst_n_out) begin
            low_run <= '0;
        end else if (low_run != LW'(HOLD_CYC + 1)) begin
            low_run <= low_run + 1'b1;
        end
    end

    p_supply_low_r2: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !rst_n_out);

    p_release_after_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_out) |-> (low_run == LW'(HOLD_CYC)));

    p_disabled_no_wd_reset_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst_n_out) && !$past(rst) && !$past(wd_en && (tmo_sel != 2'd3)))
        |-> !$past(supply_ok));

    p_no_timeout_in_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!rst_n_out && $past(!rst_n_out)) |-> !wd_expire);
endmodule

bind wdog_rst_supervisor wrs_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .tmo_sel   (tmo_sel),
    .wd_en     (wd_en),
    .rst_n_out (rst_n_out),
    .wd_expire (wd_expire)
);

// File: tb/sim_wdog_rst_supervisor.sv
module sim_wdog_rst_supervisor;
    localparam int HOLD = 20;
    localparam int TA   = 10;
    localparam int TB   = 20;
    localparam int TC   = 40;
    localparam int WIN  = 130;

    // {sel[19:18], en[17], level[16], kick period[15:8], expected first low[7:0] (0 = none)}
    localparam logic [19:0] VEC [9] = '{
        {2'd0, 1'b1, 1'b1, 8'd0,  8'd10},
        {2'd1, 1'b1, 1'b0, 8'd0,  8'd20},
        {2'd2, 1'b1, 1'b1, 8'd0,  8'd40},
        {2'd0, 1'b1, 1'b1, 8'd6,  8'd0},
        {2'd1, 1'b1, 1'b1, 8'd12, 8'd0},
        {2'd2, 1'b1, 1'b1, 8'd24, 8'd0},
        {2'd3, 1'b1, 1'b1, 8'd0,  8'd0},
        {2'd0, 1'b0, 1'b1, 8'd0,  8'd0},
        {2'd2, 1'b1, 1'b0, 8'd0,  8'd40}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b1;
    logic       cs_kick_n = 1'b1;
    logic [1:0] tmo_sel = 2'd0;
    logic       wd_en = 1'b1;
    logic       rst_n_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = !clk;

    wdog_rst_supervisor #(.HOLD_CYC(HOLD), .TMO_A(TA), .TMO_B(TB), .TMO_C(TC)) u0 (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .cs_kick_n (cs_kick_n),
        .tmo_sel   (tmo_sel),
        .wd_en     (wd_en),
        .rst_n_out (rst_n_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic power_up();
        @(negedge clk);
        rst = 1'b1;
        supply_ok = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 low in reset", int'(rst_n_out), 0);
        rst = 1'b0;
        repeat (HOLD - 1) @(negedge clk);
        check("R3 still held", int'(rst_n_out), 0);
        @(negedge clk);
        check("R3 released", int'(rst_n_out), 1);
    endtask

    task automatic run_window(input int per, input logic lvl, input int drop_at,
                              input int drop_len, output int first_low,
                              output int rel_at, output int second_low);
        first_low = -1;
        rel_at = -1;
        second_low = -1;
        for (int i = 0; i < WIN; i++) begin
            if (!rst_n_out && first_low < 0) first_low = i;
            else if (rst_n_out && first_low >= 0 && rel_at < 0) rel_at = i;
            else if (!rst_n_out && rel_at >= 0 && second_low < 0) second_low = i;
            cs_kick_n = (per != 0) ? ((i % per) < (per / 2)) : lvl;
            supply_ok = !(drop_at >= 0 && i >= drop_at && i < drop_at + drop_len);
            @(negedge clk);
        end
        supply_ok = 1'b1;
    endtask

    task automatic setup(input logic [1:0] sel, input logic en, input logic lvl, input int per);
        tmo_sel = sel;
        wd_en = en;
        cs_kick_n = (per != 0) ? 1'b1 : lvl;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int fl, ra, sl;
        // table walk: R5 steady levels, R6 code lengths, R7 kicks, R8 disable
        for (int v = 0; v < 9; v++) begin
            setup(VEC[v][19:18], VEC[v][17], VEC[v][16], int'(VEC[v][15:8]));
            power_up();
            run_window(int'(VEC[v][15:8]), VEC[v][16], -1, 0, fl, ra, sl);
            check($sformatf("R5/R6/R7/R8 vector %0d first low", v), fl,
                  (VEC[v][7:0] == 8'd0) ? -1 : int'(VEC[v][7:0]));
        end

        // R9: timeout hold then full restart of the window
        setup(2'd0, 1'b1, 1'b1, 0);
        power_up();
        run_window(0, 1'b1, -1, 0, fl, ra, sl);
        check("R9 timeout at", fl, TA);
        check("R9 release after hold", ra, TA + HOLD);
        check("R9 next timeout", sl, TA + HOLD + TA);

        // R2/R4 supply drop with watchdog off
        setup(2'd3, 1'b1, 1'b1, 0);
        power_up();
        run_window(0, 1'b1, 5, 4, fl, ra, sl);
        check("R2 supply drop reset", fl, 6);
        check("R4 release after supply return", ra, 9 + HOLD);
        check("R8 no further reset", sl, -1);

        // R10: supply drop on the timeout cycle
        setup(2'd0, 1'b1, 1'b1, 0);
        power_up();
        run_window(0, 1'b1, 9, 3, fl, ra, sl);
        check("R10 reset at coincident cycle", fl, TA);
        check("R10 hold counted from supply return", ra, 12 + HOLD);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule